// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Mode Controller

This block models the control logic of a byte-wide one-time-programmable memory. Each clock it decodes the operating mode from five inputs: chip enable, the digital level of the combined output-enable/program-voltage pin, a flag that marks a high voltage on that same pin, a flag that marks a high voltage on address line 9, and the address bits. The modes are read, output disable, standby, program, program verify, program inhibit and product identification. The data port is split the way a pad ring expects it: a write-data input, a read-data output and an output-drive enable.

The array starts with every bit at 1. Programming can only clear bits: the stored byte becomes the old byte ANDed with the write data. A program event is taken once for each low pulse of chip enable. It is applied on the first clock at which chip enable is seen high after a low pulse in which the high-voltage flag was set. The address and data used are those sampled on the last clock of that low pulse. Identification readout returns a manufacturer byte, a device byte or a continuation byte, chosen by address bits 1 and 0. The array depth is a parameter and is kept small for simulation.

Top module: `otp_mode_ctl`

## Requirements
- R1: After reset every byte reads 0xFF.
- R2: A program event stores old AND data, so a 1 in the write data never sets a bit that is already 0.
- R3: With ce_n=0, oe_n=0, vpp_hv=0 and a9_hv=0, dq_oe is 1 and dq_out is the byte at addr. This is read and program verify.
- R4: With ce_n=0, oe_n=1 and vpp_hv=0, dq_oe is 0 (output disable).
- R5: With ce_n=1, dq_oe is 0 whatever oe_n is (standby).
- R6: With vpp_hv=1 and ce_n=0, dq_oe is 0. When ce_n next rises, the addressed byte is programmed with the addr and dq_in sampled on the last clock of the low pulse, and no other byte changes.
- R7: With vpp_hv=1 and ce_n held at 1, no byte changes and dq_oe is 0 (program inhibit).
- R8: With a9_hv=1, ce_n=0, oe_n=0, vpp_hv=0 and addr[1]=1, dq_out is 0x1C when addr[0]=0 and 0x83 when addr[0]=1. Both values have odd parity, with bit 7 as the parity bit.
- R9: With a9_hv=1, ce_n=0, oe_n=0, vpp_hv=0 and addr[1]=0, dq_out is 0x7F for either value of addr[0].
- R10: With vpp_hv=1 and a9_hv=1 together, programming takes place and no identification byte is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; sets the array to all ones |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Digital level of the output-enable/program-voltage pin |
| vpp_hv | input | 1 | High voltage present on the output-enable/program-voltage pin |
| a9_hv | input | 1 | High voltage present on address line 9 |
| addr | input | AW | Byte address; bits 1 and 0 select the identification byte |
| dq_in | input | 8 | Data presented on the data pins for programming |
| dq_out | output | 8 | Data the block drives onto the data pins |
| dq_oe | output | 1 | Data pin drive enable; 0 means high impedance |

## Verification
The hardest case to reach is a write caused by a chip-enable rising edge, because the write uses state held over from the low pulse. The stimulus holds program mode for several clocks and then raises ce_n alone. A later read then shows the bit-clearing result. Further stimulus programs the same byte a second time with all-ones data, which must leave it unchanged. Program mode is also combined with the address-9 high-voltage flag, and the vector table changes from program mode to standby without a rising edge, which checks that inhibit leaves the array untouched.

// File: rtl/otp_mode_ctl.sv
module otp_mode_ctl #(
  parameter int AW = 6,
  parameter logic [7:0] MFR_CODE  = 8'h1C,
  parameter logic [7:0] DEV_CODE  = 8'h83,
  parameter logic [7:0] CONT_CODE = 8'h7F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          vpp_hv,
  input  logic          a9_hv,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_in,
  output logic [7:0]    dq_out,
  output logic          dq_oe
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic          ce_q;
  logic          arm_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [7:0]    id_byte;

  wire ce_rise = ce_n && !ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      arm_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      ce_q <= ce_n;
      if (!ce_n) begin
        arm_q  <= vpp_hv;
        addr_q <= addr;
        data_q <= dq_in;
      end
      if (ce_rise && arm_q) mem[addr_q] <= mem[addr_q] & data_q;
    end
  end

  assign id_byte = !addr[1] ? CONT_CODE : (addr[0] ? DEV_CODE : MFR_CODE);
  assign dq_oe   = !ce_n && !oe_n && !vpp_hv;
  assign dq_out  = a9_hv ? id_byte : mem[addr];
endmodule

module otp_mode_ctl_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          vpp_hv,
  input logic          a9_hv,
  input logic [AW-1:0] addr,
  input logic [7:0]    dq_out,
  input logic          dq_oe
);
  assert_standby_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dq_oe);

  assert_output_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !vpp_hv) |-> !dq_oe);

  assert_program_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hv |-> !dq_oe);

  assert_id_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && a9_hv && addr[1]) |-> ($countones(dq_out) % 2 == 1));

  assert_continuation_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && a9_hv && !addr[1]) |-> (dq_out == 8'h7F));

  assert_only_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !a9_hv && $past(dq_oe && !a9_hv) && $stable(addr))
      |-> ((dq_out & ~$past(dq_out)) == 8'h00));
endmodule

bind otp_mode_ctl otp_mode_ctl_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_otp_mode_ctl.sv
module tb_otp_mode_ctl;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, vpp_hv = 1'b0, a9_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  otp_mode_ctl #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hv(vpp_hv),
    .a9_hv(a9_hv), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // {ce_n, oe_n, vpp_hv, a9_hv, addr[5:0], exp_oe, exp_data[7:0]}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {4'b0000, 6'd5,       1'b1, 8'hFF},
    {4'b0100, 6'd5,       1'b0, 8'h00},
    {4'b1000, 6'd5,       1'b0, 8'h00},
    {4'b1100, 6'd5,       1'b0, 8'h00},
    {4'b0001, 6'b111110,  1'b1, 8'h1C},
    {4'b0001, 6'b111111,  1'b1, 8'h83},
    {4'b0001, 6'b111100,  1'b1, 8'h7F},
    {4'b0001, 6'b111101,  1'b1, 8'h7F},
    {4'b0101, 6'b111110,  1'b0, 8'h00},
    {4'b1111, 6'b111110,  1'b0, 8'h00}
  };

  task automatic check(input string req, input logic exp_oe, input logic [7:0] exp_d);
    checks++;
    if (dq_oe !== exp_oe || (exp_oe && dq_out !== exp_d)) begin
      errors++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", req, dq_oe, dq_out, exp_oe, exp_d);
    end
  endtask

  task automatic read_at(input logic [AW-1:0] a, input logic hv9, input string req,
                         input logic [7:0] exp_d);
    @(negedge clk);
    ce_n = 0; oe_n = 0; vpp_hv = 0; a9_hv = hv9; addr = a;
    #2 check(req, 1'b1, exp_d);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input logic hv9,
                      input string req);
    @(negedge clk);
    ce_n = 1; oe_n = 1; vpp_hv = 1; a9_hv = hv9; addr = a; dq_in = d;
    @(negedge clk);
    ce_n = 0;
    repeat (3) @(negedge clk);
    check(req, 1'b0, 8'h00);
    ce_n = 1;
    @(negedge clk);
    vpp_hv = 0; a9_hv = 0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2 check("R5 reset standby", 1'b0, 8'h00);
    read_at(6'd0, 0, "R1 reset byte 0", 8'hFF);
    read_at(6'd63, 0, "R1 reset byte 63", 8'hFF);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ce_n, oe_n, vpp_hv, a9_hv} = VEC[i][18:15];
      addr = VEC[i][14:9];
      #2 check($sformatf("R3 R4 R5 R8 R9 R7 vector %0d", i), VEC[i][8], VEC[i][7:0]);
    end
    @(negedge clk);
    vpp_hv = 0; a9_hv = 0;
    read_at(6'd62, 0, "R7 inhibit left byte 62", 8'hFF);

    prog(6'd5, 8'hA5, 0, "R6 float during program");
    read_at(6'd5, 0, "R6 programmed byte 5", 8'hA5);
    read_at(6'd6, 0, "R6 neighbour byte 6", 8'hFF);
    read_at(6'd4, 0, "R6 neighbour byte 4", 8'hFF);
    prog(6'd5, 8'h0F, 0, "R6 float during program");
    read_at(6'd5, 0, "R2 clear only", 8'h05);
    prog(6'd5, 8'hFF, 0, "R6 float during program");
    read_at(6'd5, 0, "R2 ones do not set", 8'h05);

    @(negedge clk);
    ce_n = 1; oe_n = 0; vpp_hv = 1; addr = 6'd6; dq_in = 8'h00;
    repeat (4) @(negedge clk);
    check("R7 inhibit float", 1'b0, 8'h00);
    vpp_hv = 0;
    read_at(6'd6, 0, "R7 inhibit no write", 8'hFF);

    prog(6'b111110, 8'h3C, 1, "R10 no id during program");
    read_at(6'b111110, 0, "R10 program wins over id", 8'h3C);
    read_at(6'b111110, 1, "R8 id after program", 8'h1C);

    @(negedge clk);
    ce_n = 1; rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    read_at(6'd5, 0, "R1 reset restores byte 5", 8'hFF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule